// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Unit

This block sits next to a processor core and watches its bus every cycle. It holds a set of comparator units. Each unit is programmed with an address value and mask, a data value and mask, and access qualifiers that select instruction fetches or data accesses, and reads, writes or either. A debug scan chain programs the units serially. Values shifted into the chain stay in a shift register until an update strobe copies them into the active comparator settings, so a load that is half done never changes the comparisons in use.

When an enabled unit sees a matching access, the block raises a registered halt request towards the core. The core answers by signalling that it has entered its debug state, where its state can be inspected. The request is held until a restart pulse arrives. A restart taken from the debug state produces a one-cycle resume pulse that lets the core continue. While a halt is pending or active, further matches are dropped.

Top module: `dbg_match_top`

## Requirements
- R1: After reset, halt_req, debug_active and resume_pulse are 0, scan_out is 0, and every comparator unit is disabled, so no bus access raises halt_req until a configuration has been loaded and updated.
- R2: The chain holds NUM_CMP*(4+2*ADDR_W+2*DATA_W) bits and is shifted LSB first. On each clock with scan_shift high the chain moves one place toward bit 0, scan_in enters the top bit, and scan_out always shows bit 0. Unit k uses bits starting at k*(4+2*ADDR_W+2*DATA_W); inside a unit, from bit 0 upward: enable (bit 0), fetch select (bit 1, 1 = instruction fetches, 0 = data accesses), any-direction (bit 2), write select (bit 3, 1 = writes), address value, address mask, data value, data mask.
- R3: The active comparator settings change only on a clock with scan_update high, where they take the chain contents; shifting without an update has no effect on matching.
- R4: A unit with fetch select 1 matches an access with bus_valid and bus_fetch high whose address equals the programmed address in all unmasked bits; a data access to the same address does not match.
- R5: A unit with fetch select 0, any-direction 0 and write select 1 matches only a data write whose address and data both equal the programmed values in all unmasked bits; a read, or a write with different data, does not match.
- R6: A set mask bit makes that address or data bit a don't-care.
- R7: A unit whose enable bit is 0 never matches; units match independently, and a match in any enabled unit counts.
- R8: halt_req rises on the clock after a matching cycle and stays high until a restart is accepted.
- R9: While halt_req is high, core_in_debug high moves the block to its debug state and debug_active goes high on the next clock; debug_active is never high without halt_req.
- R10: restart while halt_req is high clears halt_req and debug_active on the next clock; if the block was in its debug state, resume_pulse is high for exactly that one next cycle, otherwise it stays low.
- R11: Matches while halt_req is high are dropped and not queued; restart while halt_req is low has no effect.
- R12: A cycle with bus_valid low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_shift | input | 1 | Shift the configuration chain by one bit |
| scan_in | input | 1 | Serial data into the top of the chain |
| scan_update | input | 1 | Copy the chain into the active comparator settings |
| scan_out | output | 1 | Bit 0 of the chain |
| bus_valid | input | 1 | Core bus access in progress this cycle |
| bus_fetch | input | 1 | Access is an instruction fetch |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Access address |
| bus_data | input | DATA_W | Access data |
| halt_req | output | 1 | Request the core to halt |
| core_in_debug | input | 1 | Core reports it has entered its debug state |
| restart | input | 1 | Pulse to end debugging |
| debug_active | output | 1 | Block is in its debug state |
| resume_pulse | output | 1 | One-cycle pulse letting the core resume |

## Verification
The assertions check on every cycle the halt handshake: that a match while running raises halt_req, that it is held until restart and cleared by it, that a resume pulse only follows a cleared request, that debug_active implies halt_req, and that invalid cycles and disabled units never produce a hit. What a hit means, namely the field layout of the chain, mask behaviour, fetch against data and read against write selection, and that shifting alone leaves the active settings untouched, can only be shown by the bench's scenarios, which load chosen configurations and drive matching and near-miss accesses.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  // Bit positions inside one comparator's configuration slice
  localparam int F_EN    = 0;
  localparam int F_FETCH = 1;
  localparam int F_ANY   = 2;
  localparam int F_WR    = 3;
  localparam int F_ADDR  = 4;

  function automatic int cfg_width(input int aw, input int dw);
    return 4 + 2 * aw + 2 * dw;
  endfunction

  typedef enum logic [1:0] {
    HS_RUN   = 2'd0,
    HS_REQ   = 2'd1,
    HS_DEBUG = 2'd2
  } halt_state_e;

endpackage

// File: rtl/dbg_scan_cfg.sv
module dbg_scan_cfg #(
  parameter int TOT_W = 136
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_shift,
  input  logic             scan_in,
  input  logic             scan_update,
  output logic             scan_out,
  output logic [TOT_W-1:0] cfg_q
);

  logic [TOT_W-1:0] chain_q, chain_d;
  logic [TOT_W-1:0] cfg_d;

  // Next-state: chain moves toward bit 0, new bit enters at the top
  always_comb begin
    chain_d = {scan_in, chain_q[TOT_W-1:1]};
    cfg_d   = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (scan_shift) begin
      chain_q <= chain_d;
    end
  end

  // Active settings: only an update strobe copies the chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (scan_update) begin
      cfg_q <= cfg_d;
    end
  end

  assign scan_out = chain_q[0];

endmodule

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CFG_W = 4 + 2 * ADDR_W + 2 * DATA_W
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic              bus_valid,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              hit
);

  localparam int F_AMSK = F_ADDR + ADDR_W;
  localparam int F_DVAL = F_AMSK + ADDR_W;
  localparam int F_DMSK = F_DVAL + DATA_W;

  logic              en, sel_fetch, any_dir, sel_write;
  logic [ADDR_W-1:0] a_val, a_msk;
  logic [DATA_W-1:0] d_val, d_msk;
  logic              addr_ok, data_ok, kind_ok, dir_ok;

  always_comb begin
    en        = cfg[F_EN];
    sel_fetch = cfg[F_FETCH];
    any_dir   = cfg[F_ANY];
    sel_write = cfg[F_WR];
    a_val     = cfg[F_ADDR +: ADDR_W];
    a_msk     = cfg[F_AMSK +: ADDR_W];
    d_val     = cfg[F_DVAL +: DATA_W];
    d_msk     = cfg[F_DMSK +: DATA_W];

    // A set mask bit removes that bit from the comparison
    addr_ok = (((bus_addr ^ a_val) & ~a_msk) == '0);
    data_ok = (((bus_data ^ d_val) & ~d_msk) == '0);
    kind_ok = (bus_fetch == sel_fetch);
    dir_ok  = any_dir || (bus_write == sel_write);

    hit = en && bus_valid && kind_ok && dir_ok && addr_ok && data_ok;
  end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_match_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit_any,
  input  logic core_in_debug,
  input  logic restart,
  output logic halt_req,
  output logic debug_active,
  output logic resume_pulse
);

  halt_state_e st_q, st_d;
  logic        st_en;
  logic        resume_q, resume_d;

  always_comb begin
    st_d     = st_q;
    resume_d = 1'b0;
    unique case (st_q)
      HS_RUN: begin
        if (hit_any) st_d = HS_REQ;
      end
      HS_REQ: begin
        if (restart)            st_d = HS_RUN;
        else if (core_in_debug) st_d = HS_DEBUG;
      end
      HS_DEBUG: begin
        if (restart) begin
          st_d     = HS_RUN;
          resume_d = 1'b1;
        end
      end
      default: st_d = HS_RUN;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_RUN;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= 1'b0;
    end else begin
      resume_q <= resume_d;
    end
  end

  assign halt_req     = (st_q != HS_RUN);
  assign debug_active = (st_q == HS_DEBUG);
  assign resume_pulse = resume_q;

endmodule

// File: rtl/dbg_match_top.sv
module dbg_match_top
  import dbg_match_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_CMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_shift,
  input  logic              scan_in,
  input  logic              scan_update,
  output logic              scan_out,
  input  logic              bus_valid,
  input  logic              bus_fetch,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              halt_req,
  input  logic              core_in_debug,
  input  logic              restart,
  output logic              debug_active,
  output logic              resume_pulse
);

  localparam int CFG_W = 4 + 2 * ADDR_W + 2 * DATA_W;
  localparam int TOT_W = NUM_CMP * CFG_W;

  logic [TOT_W-1:0]   cfg_q;
  logic [NUM_CMP-1:0] hits;
  logic [NUM_CMP-1:0] en_vec;
  logic               hit_any;

  dbg_scan_cfg #(.TOT_W(TOT_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_shift  (scan_shift),
    .scan_in     (scan_in),
    .scan_update (scan_update),
    .scan_out    (scan_out),
    .cfg_q       (cfg_q)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    dbg_cmp_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .cfg       (cfg_q[k*CFG_W +: CFG_W]),
      .bus_valid (bus_valid),
      .bus_fetch (bus_fetch),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .hit       (hits[k])
    );
    assign en_vec[k] = cfg_q[k*CFG_W + F_EN];
  end

  assign hit_any = |hits;

  dbg_halt_ctrl u_halt (
    .clk           (clk),
    .rst_n         (rst_n),
    .hit_any       (hit_any),
    .core_in_debug (core_in_debug),
    .restart       (restart),
    .halt_req      (halt_req),
    .debug_active  (debug_active),
    .resume_pulse  (resume_pulse)
  );

endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk #(
  parameter int NUM_CMP = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               hit_any,
  input logic [NUM_CMP-1:0] hits,
  input logic [NUM_CMP-1:0] en_vec,
  input logic               restart,
  input logic               halt_req,
  input logic               debug_active,
  input logic               resume_pulse
);

  a_r8_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && hit_any) |=> halt_req);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !restart) |=> halt_req);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && restart) |=> (!halt_req && !debug_active));

  a_r10_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (!halt_req && $past(debug_active) && $past(restart)));

  a_r9_dbg_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    debug_active |-> halt_req);

  a_r11_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && restart && !hit_any) |=> (!halt_req && !resume_pulse));

  a_r12_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !hit_any);

  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (hits & ~en_vec) == '0);

endmodule

bind dbg_match_top dbg_match_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .hit_any      (hit_any),
  .hits         (hits),
  .en_vec       (en_vec),
  .restart      (restart),
  .halt_req     (halt_req),
  .debug_active (debug_active),
  .resume_pulse (resume_pulse)
);

// File: tb/tb_dbg_match_top.sv
module tb_dbg_match_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NC = 2;
  localparam int CW = 4 + 2 * AW + 2 * DW;
  localparam int TW = NC * CW;

  logic clk, rst_n;
  logic scan_shift, scan_in, scan_update, scan_out;
  logic bus_valid, bus_fetch, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic halt_req, core_in_debug, restart, debug_active, resume_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dbg_match_top #(.ADDR_W(AW), .DATA_W(DW), .NUM_CMP(NC)) dut (
    .clk(clk), .rst_n(rst_n),
    .scan_shift(scan_shift), .scan_in(scan_in), .scan_update(scan_update),
    .scan_out(scan_out),
    .bus_valid(bus_valid), .bus_fetch(bus_fetch), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .halt_req(halt_req), .core_in_debug(core_in_debug), .restart(restart),
    .debug_active(debug_active), .resume_pulse(resume_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Unit configuration laid out as R2 describes
  function automatic logic [CW-1:0] mk(input logic en, input logic fetch,
                                        input logic any, input logic wr,
                                        input logic [AW-1:0] av, input logic [AW-1:0] am,
                                        input logic [DW-1:0] dv, input logic [DW-1:0] dm);
    logic [CW-1:0] v;
    v = '0;
    v[0] = en; v[1] = fetch; v[2] = any; v[3] = wr;
    v[4 +: AW]           = av;
    v[4 + AW +: AW]      = am;
    v[4 + 2*AW +: DW]    = dv;
    v[4 + 2*AW + DW +: DW] = dm;
    return v;
  endfunction

  task automatic shift_bits(input logic [TW-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      scan_shift = 1'b1;
      scan_in    = v[i];
      @(negedge clk);
    end
    scan_shift = 1'b0;
    scan_in    = 1'b0;
  endtask

  task automatic do_update();
    scan_update = 1'b1;
    @(negedge clk);
    scan_update = 1'b0;
  endtask

  task automatic load(input logic [CW-1:0] u1, input logic [CW-1:0] u0);
    shift_bits({u1, u0}, TW);
    do_update();
  endtask

  task automatic bus_op(input logic fetch, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic valid = 1'b1);
    bus_valid = valid; bus_fetch = fetch; bus_write = wr;
    bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 halt_req", halt_req, 0);
    chk("R1 debug_active", debug_active, 0);
    chk("R1 resume_pulse", resume_pulse, 0);
    chk("R1 scan_out", scan_out, 0);
    bus_op(1, 0, 16'h0000, 16'h0000);
    chk("R1 no halt unconfigured", halt_req, 0);
  endtask

  task automatic t_breakpoint();
    logic [CW-1:0] u0;
    u0 = mk(1, 1, 1, 0, 16'h1234, 16'h0000, 16'h0000, 16'hFFFF);
    shift_bits({{CW{1'b0}}, u0}, TW);
    chk("R2 scan_out bit0", scan_out, u0[0]);
    shift_bits({TW{1'b0}}, 1);
    chk("R2 scan_out bit1", scan_out, u0[1]);
    load('0, u0);
    bus_op(0, 0, 16'h1234, 16'h5555);
    chk("R4 data read no bp", halt_req, 0);
    bus_op(1, 0, 16'h1235, 16'h0000);
    chk("R4 other addr no bp", halt_req, 0);
    bus_op(1, 0, 16'h1234, 16'h9999);
    chk("R4 R8 fetch halts", halt_req, 1);
    repeat (4) @(negedge clk);
    chk("R8 halt held", halt_req, 1);
    do_restart();
    chk("R10 cleared from req", halt_req, 0);
    chk("R10 no resume from req", resume_pulse, 0);
  endtask

  task automatic t_watch();
    load(mk(1, 0, 0, 1, 16'h0040, 16'h0000, 16'hBEEF, 16'h0000), '0);
    bus_op(0, 0, 16'h0040, 16'hBEEF);
    chk("R5 read no wp", halt_req, 0);
    bus_op(0, 1, 16'h0040, 16'hBEED);
    chk("R5 wrong data no wp", halt_req, 0);
    bus_op(1, 0, 16'h0040, 16'hBEEF);
    chk("R5 fetch no wp", halt_req, 0);
    bus_op(0, 1, 16'h0040, 16'hBEEF);
    chk("R5 R7 unit1 write halts", halt_req, 1);
    chk("R9 not yet debug", debug_active, 0);
    core_in_debug = 1'b1;
    @(negedge clk);
    core_in_debug = 1'b0;
    chk("R9 debug_active", debug_active, 1);
    do_restart();
    chk("R10 halt cleared", halt_req, 0);
    chk("R10 debug cleared", debug_active, 0);
    chk("R10 resume pulse", resume_pulse, 1);
    @(negedge clk);
    chk("R10 resume one cycle", resume_pulse, 0);
  endtask

  task automatic t_mask();
    load('0, mk(1, 1, 1, 0, 16'h1200, 16'h00FF, 16'h0000, 16'hFFFF));
    bus_op(1, 0, 16'h13AB, 16'h0000);
    chk("R6 unmasked bit differs", halt_req, 0);
    bus_op(1, 0, 16'h12AB, 16'h0000);
    chk("R6 masked bits ignored", halt_req, 1);
    do_restart();
    load(mk(1, 0, 1, 0, 16'h0000, 16'hFFFF, 16'hA500, 16'h00FF), '0);
    bus_op(0, 0, 16'h7777, 16'hA4FF);
    chk("R6 data unmasked differs", halt_req, 0);
    bus_op(0, 0, 16'h7777, 16'hA53C);
    chk("R6 data mask any dir read", halt_req, 1);
    do_restart();
  endtask

  task automatic t_enable();
    load(mk(1, 1, 1, 0, 16'h0300, 16'h0000, 16'h0, 16'hFFFF),
         mk(0, 1, 1, 0, 16'h0200, 16'h0000, 16'h0, 16'hFFFF));
    bus_op(1, 0, 16'h0200, 16'h0000);
    chk("R7 disabled unit no match", halt_req, 0);
    bus_op(1, 0, 16'h0300, 16'h0000);
    chk("R7 other unit matches", halt_req, 1);
    do_restart();
  endtask

  task automatic t_update();
    load('0, mk(1, 1, 1, 0, 16'h1000, 16'h0000, 16'h0, 16'hFFFF));
    shift_bits({{CW{1'b0}}, mk(1, 1, 1, 0, 16'h2000, 16'h0000, 16'h0, 16'hFFFF)}, TW);
    bus_op(1, 0, 16'h2000, 16'h0000);
    chk("R3 new value not live", halt_req, 0);
    shift_bits({TW{1'b1}}, 9);
    bus_op(1, 0, 16'h1000, 16'h0000);
    chk("R3 old value still live", halt_req, 1);
    do_restart();
    load('0, mk(1, 1, 1, 0, 16'h2000, 16'h0000, 16'h0, 16'hFFFF));
    bus_op(1, 0, 16'h2000, 16'h0000);
    chk("R3 live after update", halt_req, 1);
    do_restart();
  endtask

  task automatic t_halted();
    // configuration: fetch breakpoint at 0x2000 from t_update
    do_restart();
    chk("R11 restart idle no halt", halt_req, 0);
    chk("R11 restart idle no resume", resume_pulse, 0);
    bus_op(1, 0, 16'h2000, 16'h0000);
    core_in_debug = 1'b1;
    @(negedge clk);
    core_in_debug = 1'b0;
    bus_op(1, 0, 16'h2000, 16'h0000);
    restart = 1'b1;
    bus_op(1, 0, 16'h2000, 16'h0000);
    restart = 1'b0;
    chk("R11 match with restart dropped", halt_req, 0);
    chk("R11 resume", resume_pulse, 1);
    @(negedge clk);
    chk("R11 not queued", halt_req, 0);
    bus_op(1, 0, 16'h2000, 16'h0000, 1'b0);
    chk("R12 invalid cycle no match", halt_req, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    scan_shift = 0; scan_in = 0; scan_update = 0;
    bus_valid = 0; bus_fetch = 0; bus_write = 0; bus_addr = '0; bus_data = '0;
    core_in_debug = 0; restart = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_breakpoint();
    t_watch();
    t_mask();
    t_enable();
    t_update();
    t_halted();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule